// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block gathers a set of device interrupt request lines and folds them into one interrupt output for a processor. Every line first passes through a two-flop synchronizer. It can then be captured either as a level, which is pending while the device holds it active, or as an edge, which is latched so that a single-cycle pulse is kept. A per-line enable mask removes lines from consideration. The meaning of a mask bit (1 enables or 1 disables) is fixed by a parameter. A request also takes part only if its static priority is strictly above the processor's current priority level.

The surviving requests are arbitrated either by fixed priority, where a lower index wins, or by a rotating scheme that serves lines in turn. A register selects the scheme. When the processor pulses the acknowledge input, the controller registers a vector code, which is a base value plus the winning line index. It also clears that line's edge latch and, in rotating mode, moves the rotation start to the next line. If nothing qualifies at acknowledge, the controller returns the all-ones spurious code and changes no other state. A small write port sets the mask, trigger type, active polarity and arbitration mode.

Top module: `irq_prio_ctrl`

## Requirements
- R1: `irq_o` is high exactly when at least one line is pending, enabled and above the threshold. After reset `irq_o` is 0 and `vec_o` is all ones.
- R2: Each line has one mask bit. With `MASK_ONE_EN`=1 a mask bit of 1 enables the line; with `MASK_ONE_EN`=0 a mask bit of 1 disables it. A disabled line never raises `irq_o` and never wins.
- R3: A level-captured line is pending while its active-level input is held, including after it is acknowledged. It stops being pending once the input is released.
- R4: An edge-captured line latches on the active edge, which is rising for polarity bit 0 and falling for polarity bit 1. The latch keeps the request after the input returns inactive and is cleared only when that line is acknowledged. A polarity bit of 1 makes a level line active-low.
- R5: In fixed mode the qualified line with the lowest index wins.
- R6: In rotating mode the search starts at a pointer that resets to 0. On an acknowledge with a winner, the pointer moves to winner+1, wrapping to 0 after the last line. It moves at no other time.
- R7: Line i has priority N_LINES−i. It qualifies only if that value is strictly greater than `thr_i`.
- R8: On the clock edge where `ack_i` is sampled with a winner, `vec_o` becomes `VEC_BASE`+index. `vec_o` holds that value until the next acknowledge.
- R9: An acknowledge with no qualified line sets `vec_o` to all ones. It clears no latch and leaves the rotation pointer unchanged.
- R10: Writes with `wr_en_i`=1 select a register by `wr_sel_i`: 0 is the mask, 1 is the trigger type (bit=1 edge), 2 is the arbitration mode in bit 0 (1 rotating), 3 is the polarity. The reset values are all lines disabled, level capture, fixed mode and polarity 0.
- R11: A level request driven between clock edges raises `irq_o` after the second rising edge and not after the first. An edge request raises it after the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_LINES | Asynchronous device request lines |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Register select |
| wr_data_i | input | N_LINES | Register write data |
| thr_i | input | $clog2(N_LINES+1) | Processor priority level |
| ack_i | input | 1 | Interrupt acknowledge, one cycle |
| irq_o | output | 1 | Combined interrupt to the processor |
| vec_o | output | VEC_W | Vector code registered on acknowledge |

## Verification
The checks assume that `ack_i` is a single-cycle pulse sampled on one edge. They also assume that `thr_i` and the configuration registers stay still while an acknowledge is being sampled, so that the winner seen by the checker matches the one the controller latches. The bench drives every input on the falling edge, pulses acknowledge for exactly one cycle, and changes the threshold and the registers only between acknowledges. It leaves several cycles after each request change so that the synchronizer has settled before any acknowledge.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  typedef enum logic [1:0] {
    SEL_MASK = 2'd0,
    SEL_TRIG = 2'd1,
    SEL_ARB  = 2'd2,
    SEL_POL  = 2'd3
  } reg_sel_e;

  typedef enum logic {
    ARB_FIXED  = 1'b0,
    ARB_ROTATE = 1'b1
  } arb_mode_e;
endpackage

// File: rtl/irq_line_capture.sv
module irq_line_capture #(
  parameter int N_LINES = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] req_i,
  input  logic [N_LINES-1:0] pol_i,
  input  logic [N_LINES-1:0] edge_i,
  input  logic [N_LINES-1:0] clr_i,
  output logic [N_LINES-1:0] pend_o
);
  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    logic [1:0] sync_q;
    logic       prev_q;
    logic       latch_q;
    logic       act;

    assign act = sync_q[1] ^ pol_i[g];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sync_q  <= '0;
        prev_q  <= 1'b0;
        latch_q <= 1'b0;
      end else begin
        sync_q  <= {sync_q[0], req_i[g]};
        prev_q  <= act;
        // a fresh edge wins over a same-cycle clear
        latch_q <= edge_i[g] & ((latch_q & ~clr_i[g]) | (act & ~prev_q));
      end
    end

    assign pend_o[g] = edge_i[g] ? latch_q : act;
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter int N_LINES = 8,
  localparam int IDX_W  = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0] qual_i,
  input  logic [IDX_W-1:0]   start_i,
  output logic               found_o,
  output logic [IDX_W-1:0]   idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int k = 0; k < N_LINES; k++) begin
      int pos;
      pos = int'(start_i) + k;
      if (pos >= N_LINES) pos = pos - N_LINES;
      if (!found_o && qual_i[pos]) begin
        found_o = 1'b1;
        idx_o   = IDX_W'(pos);
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctrl.sv
module irq_prio_ctrl
  import irq_prio_pkg::*;
#(
  parameter int N_LINES     = 8,
  parameter int VEC_W       = 8,
  parameter int VEC_BASE    = 64,
  parameter bit MASK_ONE_EN = 1'b1,
  localparam int IDX_W      = $clog2(N_LINES),
  localparam int THR_W      = $clog2(N_LINES + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_LINES-1:0] req_i,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_sel_i,
  input  logic [N_LINES-1:0] wr_data_i,
  input  logic [THR_W-1:0]   thr_i,
  input  logic               ack_i,
  output logic               irq_o,
  output logic [VEC_W-1:0]   vec_o
);
  localparam logic [N_LINES-1:0] MASK_RST = MASK_ONE_EN ? '0 : '1;

  logic [N_LINES-1:0] mask_q, trig_q, pol_q;
  arb_mode_e          arb_q;
  logic [IDX_W-1:0]   ptr_q;
  logic [VEC_W-1:0]   vec_q;

  logic [N_LINES-1:0] pend, enable, above, qual_vec, clr;
  logic               found, rr_mode;
  logic [IDX_W-1:0]   win_idx, start, next_ptr;

  // register write port
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_q <= MASK_RST;
      trig_q <= '0;
      pol_q  <= '0;
      arb_q  <= ARB_FIXED;
    end else if (wr_en_i) begin
      case (reg_sel_e'(wr_sel_i))
        SEL_MASK: mask_q <= wr_data_i;
        SEL_TRIG: trig_q <= wr_data_i;
        SEL_ARB:  arb_q  <= arb_mode_e'(wr_data_i[0]);
        SEL_POL:  pol_q  <= wr_data_i;
        default:  ;
      endcase
    end
  end

  irq_line_capture #(.N_LINES(N_LINES)) u_cap (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .req_i  (req_i),
    .pol_i  (pol_q),
    .edge_i (trig_q),
    .clr_i  (clr),
    .pend_o (pend)
  );

  if (MASK_ONE_EN) begin : g_mask_hi
    assign enable = mask_q;
  end else begin : g_mask_lo
    assign enable = ~mask_q;
  end

  for (genvar g = 0; g < N_LINES; g++) begin : g_thr
    localparam logic [THR_W-1:0] PRIO = THR_W'(N_LINES - g);
    assign above[g] = PRIO > thr_i;
  end

  assign qual_vec = pend & enable & above;
  assign irq_o    = |qual_vec;
  assign rr_mode  = (arb_q == ARB_ROTATE);
  assign start    = rr_mode ? ptr_q : '0;

  irq_arbiter #(.N_LINES(N_LINES)) u_arb (
    .qual_i  (qual_vec),
    .start_i (start),
    .found_o (found),
    .idx_o   (win_idx)
  );

  assign next_ptr = (int'(win_idx) == N_LINES - 1) ? '0 : win_idx + 1'b1;
  assign clr      = (ack_i && found) ? (N_LINES'(1) << win_idx) : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      vec_q <= '1;
    end else if (ack_i) begin
      if (found) begin
        vec_q <= VEC_W'(VEC_BASE) + VEC_W'(win_idx);
        if (rr_mode) ptr_q <= next_ptr;
      end else begin
        vec_q <= '1;
      end
    end
  end

  assign vec_o = vec_q;
endmodule

// File: rtl/irq_prio_ctrl_chk.sv
module irq_prio_ctrl_chk #(
  parameter int N_LINES  = 8,
  parameter int VEC_W    = 8,
  parameter int VEC_BASE = 64,
  localparam int THR_W   = $clog2(N_LINES + 1)
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               ack_i,
  input logic               irq_o,
  input logic [VEC_W-1:0]   vec_o,
  input logic [THR_W-1:0]   thr_i,
  input logic [N_LINES-1:0] qual_i,
  input logic               rr_i
);
  function automatic logic [VEC_W-1:0] lowest(input logic [N_LINES-1:0] v);
    logic [VEC_W-1:0] r;
    r = '0;
    for (int i = N_LINES - 1; i >= 0; i--) if (v[i]) r = VEC_W'(i);
    return r;
  endfunction

  assert_spurious_vec_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !irq_o) |=> (vec_o == '1));

  assert_vec_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ack_i |=> $stable(vec_o));

  assert_vec_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o) |=> ((vec_o - VEC_W'(VEC_BASE)) < VEC_W'(N_LINES)));

  assert_thr_block_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(thr_i) >= N_LINES) |-> !irq_o);

  assert_fixed_win_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && irq_o && !rr_i) |=> (vec_o == VEC_W'(VEC_BASE) + lowest($past(qual_i))));
endmodule

bind irq_prio_ctrl irq_prio_ctrl_chk #(
  .N_LINES  (N_LINES),
  .VEC_W    (VEC_W),
  .VEC_BASE (VEC_BASE)
) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .ack_i  (ack_i),
  .irq_o  (irq_o),
  .vec_o  (vec_o),
  .thr_i  (thr_i),
  .qual_i (qual_vec),
  .rr_i   (rr_mode)
);

// File: tb/tb_irq_prio_ctrl.sv
module tb_irq_prio_ctrl;
  localparam int N    = 8;
  localparam int BASE = 64;
  localparam int TW   = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req = '0;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_sel = '0;
  logic [N-1:0]  wr_data = '0;
  logic [TW-1:0] thr = '0;
  logic          ack = 1'b0;
  logic          irq, irq_inv;
  logic [7:0]    vec, vec_inv;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  irq_prio_ctrl #(.N_LINES(N), .VEC_W(8), .VEC_BASE(BASE), .MASK_ONE_EN(1'b1)) dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .thr_i(thr), .ack_i(ack), .irq_o(irq), .vec_o(vec));

  irq_prio_ctrl #(.N_LINES(N), .VEC_W(8), .VEC_BASE(BASE), .MASK_ONE_EN(1'b0)) dut_inv (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wr_en_i(wr_en), .wr_sel_i(wr_sel),
    .wr_data_i(wr_data), .thr_i(thr), .ack_i(ack), .irq_o(irq_inv), .vec_o(vec_inv));

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] sel, input logic [N-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_ack();
    @(negedge clk);
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  function automatic int low_idx(input logic [N-1:0] p);
    int r = -1;
    for (int i = N - 1; i >= 0; i--) if (p[i]) r = i;
    return r;
  endfunction

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    chk("R1 reset irq", int'(irq), 0);
    chk("R1 reset vec", int'(vec), 255);
    chk("R10 reset mask inv", int'(irq_inv), 0);

    // R2 / R10 mask and polarity
    req = '1; step(4);
    chk("R10 reset mask disables", int'(irq), 0);
    wr(2'd0, '1); step(1);
    chk("R2 ones enable", int'(irq), 1);
    chk("R2 ones disable (inv)", int'(irq_inv), 0);
    wr(2'd0, '0); step(1);
    chk("R2 zeros disable", int'(irq), 0);
    chk("R2 zeros enable (inv)", int'(irq_inv), 1);
    wr(2'd0, '1);

    // R11 latency of a level line
    req = '0; step(4);
    req[5] = 1'b1;
    @(negedge clk);
    chk("R11 one edge", int'(irq), 0);
    @(negedge clk);
    chk("R11 two edges", int'(irq), 1);
    req = '0; step(4);

    // R5 / R1 exhaustive fixed-priority sweep
    for (int p = 1; p < (1 << N); p++) begin
      req = N'(p); step(4);
      chk("R1 or of requests", int'(irq), 1);
      do_ack();
      chk("R5 lowest wins", int'(vec), BASE + low_idx(N'(p)));
    end

    // R3 level behaviour
    req = 8'h10; step(4);
    do_ack();
    chk("R3 vec line4", int'(vec), BASE + 4);
    chk("R3 held after ack", int'(irq), 1);
    step(3);
    chk("R8 vec stable", int'(vec), BASE + 4);
    req = '0; step(3);
    chk("R3 released", int'(irq), 0);

    // R9 spurious
    do_ack();
    chk("R9 spurious vec", int'(vec), 255);
    step(5);
    chk("R8 spurious stable", int'(vec), 255);

    // R7 threshold sweep
    for (int j = 0; j < N; j++) begin
      req = N'(1) << j; step(4);
      for (int t = 0; t <= N; t++) begin
        thr = TW'(t); step(1);
        chk("R7 threshold", int'(irq), ((N - j) > t) ? 1 : 0);
        if ((N - j) > t) begin
          do_ack();
          chk("R7 vec", int'(vec), BASE + j);
        end
      end
    end
    thr = '0; req = '0; step(4);

    // R4 edge capture
    wr(2'd1, '1); step(3);
    req[3] = 1'b1; @(negedge clk); req[3] = 1'b0;
    step(5);
    chk("R4 pulse latched", int'(irq), 1);
    do_ack();
    chk("R4 vec line3", int'(vec), BASE + 3);
    chk("R4 latch cleared", int'(irq), 0);
    req[6] = 1'b1; req[2] = 1'b1; @(negedge clk); req = '0;
    step(5);
    do_ack();
    chk("R4 first of two", int'(vec), BASE + 2);
    chk("R4 second kept", int'(irq), 1);
    do_ack();
    chk("R4 second", int'(vec), BASE + 6);
    chk("R4 both cleared", int'(irq), 0);
    req[1] = 1'b1; step(5);
    do_ack();
    chk("R4 held vec", int'(vec), BASE + 1);
    step(3);
    chk("R4 held input no retrigger", int'(irq), 0);
    req = '0; step(4);
    wr(2'd1, '0);

    // R4 active-low polarity on a level line
    wr(2'd3, 8'h04); step(4);
    chk("R4 active low pending", int'(irq), 1);
    do_ack();
    chk("R4 active low vec", int'(vec), BASE + 2);
    wr(2'd3, '0); step(4);
    chk("R4 polarity back", int'(irq), 0);

    // R6 rotating arbitration
    wr(2'd2, 8'h01);
    req = '1; step(4);
    for (int k = 0; k <= N; k++) begin
      do_ack();
      chk("R6 rotate all", int'(vec), BASE + (k % N));
    end
    req = 8'h42; step(4);
    do_ack(); chk("R6 sparse a", int'(vec), BASE + 1);
    do_ack(); chk("R6 sparse b", int'(vec), BASE + 6);
    do_ack(); chk("R6 sparse c", int'(vec), BASE + 1);
    req = '0; step(4);
    do_ack(); chk("R9 spurious in rotate", int'(vec), 255);
    req = 8'h42; step(4);
    do_ack(); chk("R9 pointer unchanged", int'(vec), BASE + 6);

    // R10 back to fixed mode
    wr(2'd2, 8'h00);
    req = '1; step(4);
    do_ack(); chk("R10 fixed again a", int'(vec), BASE);
    do_ack(); chk("R10 fixed again b", int'(vec), BASE);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule